// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a clocked host to an external asynchronous static RAM of 16-bit words. The RAM has separate active-low enables for its upper and lower byte. The host gives one request at a time: a word address, write data, a two-bit byte mask and a read/write flag. The host keeps the request steady until the controller raises a one-cycle completion pulse. While that pulse is high, read data is valid.

On the memory side the controller drives these signals:
- active-low chip select, write strobe and read (output) enable;
- two active-low byte-lane enables;
- the address.

The 16-bit data bus is split into a drive value, a drive enable and an input. The top level joins them into a real tristate bus. The strobe length is a parameter counted in clock cycles, so it can be sized to the part's access time at the system clock. Address, byte enables and write data come from registers and stay fixed for the whole access. The controller drives the data bus only while it is writing. It releases the part whenever no access is in progress.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high, and at the first edge after reset rises, the following hold:
  - `memCeN`, `memWeN` and `memOeN` are high;
  - both bits of `memBeN` are high;
  - `memDqOe` is low and `reqReady` is low.
- R2: Whenever `memCeN` is high, both byte-lane enables are high, so the part is always deselected when idle.
- R3: A write follows a fixed sequence:
  - `memCeN` goes low, and the address and lane enables are presented, one cycle before `memWeN` falls;
  - `memWeN` stays low for exactly STROBE_CYC cycles;
  - `memWeN` rises one cycle before `memCeN` is released;
  - address and driven data stay constant while `memCeN` is low.
- R4: Mask bit 0 selects the lower byte, data bits [7:0], on `memBeN[0]`. Mask bit 1 selects the upper byte, bits [15:8], on `memBeN[1]`. A write changes only the bytes whose mask bit is 1.
- R5: A read holds `memCeN` and `memOeN` low, with `memWeN` high, for exactly STROBE_CYC cycles. The data is sampled on the last of those cycles.
- R6: A read returns the memory byte in each lane whose mask bit is 1, and zero in each lane whose mask bit is 0.
- R7: `memDqOe` is never high while `memOeN` is low. `memOeN` stays high through a write. `memDqOe` is low in the cycle after a read strobe ends.
- R8: A write accepted on the first idle cycle after a read completes waits one extra turnaround cycle. A write that directly follows a write does not.
- R9: A request whose mask is 00 raises `reqReady` one cycle after it is accepted. It leaves `memCeN` high throughout and returns zero read data.
- R10: `reqReady` is a one-cycle pulse. Counted in clock edges from the edge that accepts an idle request, it appears after STROBE_CYC+2 edges for a write and STROBE_CYC+1 edges for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present; held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | DATA_W/8 | Active-high byte mask, bit 0 = low byte |
| reqReady | output | 1 | One-cycle completion pulse |
| rspData | output | DATA_W | Read data, valid with reqReady |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | DATA_W/8 | Byte-lane enables, active low |
| memDqOut | output | DATA_W | Data to drive onto the bus |
| memDqOe | output | 1 | Bus drive enable |
| memDqIn | input | DATA_W | Data read from the bus |

## Verification
The bench builds the controller with a 4-bit address (16 words) and a strobe of 3 cycles. It does not use the full 18-bit, 6-cycle default. With that size it can write every address under all four byte masks, twice with different data, and then read every address back under every mask. That covers each lane-merge and lane-zeroing case against a shadow copy the bench keeps itself. The short strobe keeps the latency figures small enough to check exactly for these cases:
- idle starts;
- write after write;
- the turnaround of a write placed directly behind a read.

A bus monitor runs throughout and checks strobe widths, setup and hold ordering, and drive/output-enable exclusion.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } ctrlState_e;

  // Strobes from the control unit to the datapath and pins.
  typedef struct packed {
    logic capture;   // load host request this cycle
    logic selOn;     // chip selected
    logic wrOn;      // write strobe active
    logic rdOn;      // output enable active
    logic driveOn;   // controller drives the bus
    logic sampleOn;  // last read strobe cycle
    logic doneOn;    // completion pulse
  } laneStrobe_t;

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int STROBE_CYC = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqNone,
  output laneStrobe_t strobe
);

  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);
  localparam int RUN_W = $clog2(STROBE_CYC + 2);

  ctrlState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic isWriteQ, isWriteD;
  logic rdTailQ, rdTailD;
  logic selQ, wrQ, rdQ, driveQ, sampleQ, doneQ;
  logic accept;

  assign accept = (stateQ == ST_IDLE) && reqValid;

  always_comb begin
    stateD   = stateQ;
    cntD     = cntQ;
    isWriteD = isWriteQ;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          isWriteD = reqWrite;
          if (reqNone)                 stateD = ST_DONE;
          else if (reqWrite && rdTailQ) stateD = ST_TURN;
          else                          stateD = ST_SETUP;
        end
      end
      ST_TURN:  stateD = ST_SETUP;
      ST_SETUP: begin
        stateD = ST_STROBE;
        cntD   = '0;
      end
      ST_STROBE: begin
        if (cntQ == CNT_LAST) stateD = isWriteQ ? ST_HOLD : ST_DONE;
        else                  cntD   = cntQ + 1'b1;
      end
      ST_HOLD:  stateD = ST_DONE;
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  // Read tail: high from the end of a read strobe through the next idle cycle.
  always_comb begin
    if (stateQ == ST_STROBE && stateD == ST_DONE) rdTailD = 1'b1;
    else if (stateQ == ST_DONE)                   rdTailD = rdTailQ;
    else                                          rdTailD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      isWriteQ <= 1'b0;
      rdTailQ  <= 1'b0;
      selQ     <= 1'b0;
      wrQ      <= 1'b0;
      rdQ      <= 1'b0;
      driveQ   <= 1'b0;
      sampleQ  <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      stateQ   <= stateD;
      cntQ     <= cntD;
      isWriteQ <= isWriteD;
      rdTailQ  <= rdTailD;
      selQ     <= (stateD == ST_SETUP) || (stateD == ST_STROBE) || (stateD == ST_HOLD);
      wrQ      <= (stateD == ST_STROBE) && isWriteD;
      rdQ      <= (stateD == ST_STROBE) && !isWriteD;
      driveQ   <= isWriteD && ((stateD == ST_SETUP) || (stateD == ST_STROBE) || (stateD == ST_HOLD));
      sampleQ  <= (stateD == ST_STROBE) && !isWriteD && (cntD == CNT_LAST);
      doneQ    <= (stateD == ST_DONE);
    end
  end

  always_comb begin
    strobe.capture  = accept;
    strobe.selOn    = selQ;
    strobe.wrOn     = wrQ;
    strobe.rdOn     = rdQ;
    strobe.driveOn  = driveQ;
    strobe.sampleOn = sampleQ;
    strobe.doneOn   = doneQ;
  end

  // Run-length counters for strobe-width checks.
  logic [RUN_W-1:0] wrRunQ, rdRunQ;
  always_ff @(posedge clk) begin
    if (rst) begin
      wrRunQ <= '0;
      rdRunQ <= '0;
    end else begin
      wrRunQ <= wrQ ? wrRunQ + 1'b1 : '0;
      rdRunQ <= rdQ ? rdRunQ + 1'b1 : '0;
    end
  end

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE) |-> !selQ);

  assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(wrQ) |-> (wrRunQ == RUN_W'(STROBE_CYC)));

  assert_oe_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rdQ) |-> (rdRunQ == RUN_W'(STROBE_CYC)));

  assert_sample_in_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    sampleQ |-> (rdQ && !wrQ));

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  captureOn,
  input  logic                  selOn,
  input  logic                  driveOn,
  input  logic                  sampleOn,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqMask,
  input  logic [DATA_W-1:0]     memDqIn,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W/8-1:0]   memBeN,
  output logic [DATA_W-1:0]     memDqOut,
  output logic [DATA_W-1:0]     rspData
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (captureOn) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk) begin
      if (rst || captureOn) laneQ <= '0;
      else if (sampleOn)    laneQ <= maskQ[l] ? memDqIn[l*8 +: 8] : 8'h00;
    end
    assign rspData[l*8 +: 8] = laneQ;
    assign memBeN[l]         = !(selOn && maskQ[l]);
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (selOn && $past(selOn)) |-> $stable(memAddr));

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (driveOn && $past(driveOn)) |-> $stable(memDqOut));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                reqReady,
  output logic [DATA_W-1:0]   rspData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memBeN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  laneStrobe_t strobe;

  sram_lane_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqNone  (~|reqMask),
    .strobe   (strobe)
  );

  sram_lane_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .captureOn (strobe.capture),
    .selOn     (strobe.selOn),
    .driveOn   (strobe.driveOn),
    .sampleOn  (strobe.sampleOn),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqMask   (reqMask),
    .memDqIn   (memDqIn),
    .memAddr   (memAddr),
    .memBeN    (memBeN),
    .memDqOut  (memDqOut),
    .rspData   (rspData)
  );

  assign memCeN   = !strobe.selOn;
  assign memWeN   = !strobe.wrOn;
  assign memOeN   = !strobe.rdOn;
  assign memDqOe  = strobe.driveOn;
  assign reqReady = strobe.doneOn;

  assert_no_bus_fight_R7: assert property (@(posedge clk) disable iff (rst)
    memDqOe |-> memOeN);

  assert_release_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(memOeN) |-> !memDqOe);

  assert_we_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> !$past(memCeN));

  assert_we_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (!memCeN && memDqOe));

  assert_deselect_lanes_R2: assert property (@(posedge clk) disable iff (rst)
    memCeN |-> (&memBeN));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NS = 3;
  localparam int LN = DW / 8;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          reqValid, reqWrite;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;
  logic [LN-1:0] reqMask;
  logic          reqReady;
  logic [DW-1:0] rspData;
  logic [AW-1:0] memAddr;
  logic          memCeN, memWeN, memOeN, memDqOe;
  logic [LN-1:0] memBeN;
  logic [DW-1:0] memDqOut, memDqIn;

  sram_lane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STROBE_CYC(NS)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqReady(reqReady), .rspData(rspData), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memBeN(memBeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Memory model: drives enabled lanes only under a valid read combination.
  logic [DW-1:0] memArr [WORDS];
  logic [DW-1:0] shadow [WORDS];

  always_comb begin
    for (int l = 0; l < LN; l++) begin
      if (!memCeN && !memOeN && memWeN && !memBeN[l])
        memDqIn[l*8 +: 8] = memArr[memAddr][l*8 +: 8];
      else
        memDqIn[l*8 +: 8] = 8'hEE;
    end
  end

  bit monOn = 0;
  logic prevWeN = 1, prevCeN = 1, prevOeN = 1;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevDq = '0;
  int weRun = 0, oeRun = 0, ceLowCnt = 0;

  always @(negedge clk) begin
    if (monOn) begin
      if (!memCeN && !memWeN) begin
        check(memDqOe && memOeN, "R7 drive during write", {memDqOe, memOeN}, 2'b11);
        for (int l = 0; l < LN; l++)
          if (!memBeN[l]) memArr[memAddr][l*8 +: 8] = memDqOut[l*8 +: 8];
      end
      if (memDqOe) check(memOeN, "R7 no fight", memOeN, 1);
      if (memCeN) check(memBeN == 2'b11, "R2 deselect lanes", memBeN, 2'b11);
      else ceLowCnt++;
      if (!memWeN && prevWeN) check(!prevCeN, "R3 ce before we", prevCeN, 0);
      if (memWeN && !prevWeN)
        check(!memCeN && memDqOe && memAddr == prevAddr && memDqOut == prevDq,
              "R3 hold after we", {memCeN, memDqOe}, 2'b01);
      if (!memCeN && !prevCeN)
        check(memAddr == prevAddr, "R3 address stable", memAddr, prevAddr);
      if (!memWeN) weRun++;
      else if (weRun > 0) begin
        check(weRun == NS, "R3 we width", weRun, NS);
        weRun = 0;
      end
      if (!memOeN) begin
        oeRun++;
        check(memWeN && !memCeN, "R5 read combination", {memWeN, memCeN}, 2'b10);
      end else if (oeRun > 0) begin
        check(oeRun == NS, "R5 oe width", oeRun, NS);
        check(!memDqOe, "R7 release after read", memDqOe, 0);
        oeRun = 0;
      end
    end
    prevWeN  = memWeN;
    prevCeN  = memCeN;
    prevOeN  = memOeN;
    prevAddr = memAddr;
    prevDq   = memDqOut;
  end

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [LN-1:0] m, output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
    end while (!reqReady && lat < 500);
    rd = rspData;
    reqValid = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int m, input int p);
    return 16'h3C5A ^ DW'(a * 16'h0911) ^ DW'(m * 16'h4101) ^ DW'(p * 16'h8421);
  endfunction

  function automatic logic [DW-1:0] laneMask(input logic [LN-1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd, exp;
    int lat;
    rst = 1; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0; reqMask = '0;
    for (int i = 0; i < WORDS; i++) begin
      memArr[i] = DW'(i * 16'h1111) ^ 16'h5A5A;
      shadow[i] = memArr[i];
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(memCeN && memWeN && memOeN, "R1 controls high", {memCeN, memWeN, memOeN}, 3'b111);
    check(memBeN == 2'b11, "R1 lanes high", memBeN, 2'b11);
    check(!memDqOe && !reqReady, "R1 drive off", {memDqOe, reqReady}, 2'b00);
    @(negedge clk); rst = 0; monOn = 1;
    @(posedge clk); #1;
    check(memCeN && !memDqOe, "R1 after release", {memCeN, memDqOe}, 2'b10);

    // R4 write sweep: every address, every mask, two data passes
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < WORDS; a++)
        for (int m = 0; m < 4; m++) begin
          doOp(1'b1, AW'(a), pat(a, m, p), LN'(m), rd, lat);
          shadow[a] = (shadow[a] & ~laneMask(LN'(m))) | (pat(a, m, p) & laneMask(LN'(m)));
        end
    // R4 / R6 read sweep
    for (int a = 0; a < WORDS; a++)
      for (int m = 0; m < 4; m++) begin
        doOp(1'b0, AW'(a), '0, LN'(m), rd, lat);
        exp = shadow[a] & laneMask(LN'(m));
        check(rd == exp, (m == 3) ? "R4 stored word" : "R6 lane zeroing", rd, exp);
      end

    // R10 latencies from idle
    repeat (3) @(negedge clk);
    doOp(1'b1, 4'd5, 16'hBEEF, 2'b11, rd, lat);
    shadow[5] = 16'hBEEF;
    check(lat == NS + 3, "R10 write latency", lat, NS + 3);
    @(posedge clk); #1;
    check(!reqReady, "R10 ready one cycle", reqReady, 0);
    repeat (2) @(negedge clk);
    doOp(1'b0, 4'd5, '0, 2'b11, rd, lat);
    check(lat == NS + 2, "R10 read latency", lat, NS + 2);
    check(rd == 16'hBEEF, "R5 read data", rd, 16'hBEEF);
    // R8 write straight after a read: one turnaround cycle
    doOp(1'b1, 4'd6, 16'h1234, 2'b01, rd, lat);
    shadow[6] = (shadow[6] & 16'hFF00) | 16'h0034;
    check(lat == NS + 5, "R8 turnaround", lat, NS + 5);
    // R8 write straight after a write: none
    doOp(1'b1, 4'd7, 16'hA1B2, 2'b10, rd, lat);
    shadow[7] = (shadow[7] & 16'h00FF) | 16'hA100;
    check(lat == NS + 4, "R8 no turnaround", lat, NS + 4);

    // R9 empty mask read and write
    repeat (2) @(negedge clk);
    ceLowCnt = 0;
    doOp(1'b0, 4'd6, '0, 2'b00, rd, lat);
    check(lat == 1, "R9 empty latency", lat, 1);
    check(rd == 16'h0, "R9 empty data", rd, 0);
    doOp(1'b1, 4'd6, 16'hFFFF, 2'b00, rd, lat);
    @(negedge clk);
    check(ceLowCnt == 0, "R9 memory untouched", ceLowCnt, 0);
    for (int a = 5; a < 8; a++) begin
      doOp(1'b0, AW'(a), '0, 2'b11, rd, lat);
      check(rd == shadow[a], "R4 final contents", rd, shadow[a]);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule